// File: doc/BRIEF.md
# Word-to-Byte Block Transfer Engine

This block moves a run of 16-bit words between a word-wide local store and a byte-wide external memory bus. A one-cycle start pulse supplies the first bus byte address, the first local word index, the number of words, a direction flag and a packing mode. The engine then walks the run on its own. It fetches words from the local store and splits them into bus byte writes, or it collects bus byte reads into words and writes them back to the local store. It raises a one-cycle done pulse when the run is finished.

Three packing modes decide how a word maps onto bus bytes. Full-byte mode uses two bus bytes per word, upper half first. Low-byte mode uses one bus byte per word and carries only the lower half. Nybble mode spreads one word over four bus bytes, one nybble per byte, starting with the most significant nybble. Nybble mode exists only in the local-to-bus direction. Each bus access is a request held until the far side acknowledges it. The bus byte address then moves up by one and wraps over the 20-bit space.

Top module: `wbx_block_mover`

## Requirements
- R1: With `start_pack`=0 (full bytes) and `start_to_bus`=1, each word produces two bus writes: bits 15:8 at the lower byte address, then bits 7:0 at the next one.
- R2: With `start_pack`=1 (low byte) and `start_to_bus`=1, each word produces exactly one bus write carrying bits 7:0 of the word.
- R3: With `start_pack`=1 and `start_to_bus`=0, each bus byte read is written to the local store as one word, with the byte in bits 7:0 and bits 15:8 set to zero.
- R4: With `start_pack`=2 (nybble) and `start_to_bus`=1, each word produces four bus writes of {4'b0000, nybble}, taking bits 15:12, 11:8, 7:4 and 3:0 in that order.
- R5: With `start_pack`=0 and `start_to_bus`=0, two consecutive bus reads form one local word: the first byte goes to bits 15:8 and the second to bits 7:0.
- R6: A start with `start_pack`=2 and `start_to_bus`=0, or with `start_pack`=3, makes no bus access and no done pulse. It raises `err` for one cycle, in the cycle after the start.
- R7: The first bus access uses `start_bus_addr`. Each later access uses the previous address plus one, modulo 2^20.
- R8: A legal start with `start_words`=0 makes no bus or local access and raises `done` in the cycle after the start.
- R9: `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until `bus_ack` is sampled high. The next access begins only after that acknowledge.
- R10: `done` is a single-cycle pulse after the last access of the run. A run of N words performs exactly N x (bytes per word) bus accesses.
- R11: Local words are used at `start_word_idx`, `start_word_idx`+1, and so on, one per word. A read run writes no local word outside that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| start_bus_addr | input | BUS_AW | First bus byte address |
| start_word_idx | input | LOC_AW | First local word index |
| start_words | input | CNT_W | Number of words in the run |
| start_to_bus | input | 1 | 1: local to bus (write), 0: bus to local (read) |
| start_pack | input | 2 | 0 full bytes, 1 low byte, 2 nybbles, 3 reserved |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected start |
| loc_addr | output | LOC_AW | Local word index |
| loc_re | output | 1 | Local read strobe; data expected on `loc_rdata` one cycle later |
| loc_rdata | input | 16 | Local read data |
| loc_we | output | 1 | Local write strobe |
| loc_wdata | output | 16 | Local write data |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = byte write, 0 = byte read |
| bus_addr | output | BUS_AW | Bus byte address |
| bus_wdata | output | 8 | Bus write byte |
| bus_rdata | input | 8 | Bus read byte, valid together with `bus_ack` |
| bus_ack | input | 1 | Acknowledge that completes the current access |

## Verification
The bench runs every mode and direction with counts of zero to three words. Start addresses include one just below the top of the 20-bit space, and the acknowledge delay changes from run to run. If the two halves of a word were swapped, every full-byte write and read would show the bytes reversed. If a design took the nybbles from the low end first, or left the upper four bits set, nybble writes would carry wrong data. If the upper half were kept on low-byte reads, stale store contents would show through. A design that carried the address into a wider counter, or moved it on without an acknowledge, would give a wrong address at the wrap point or during a held request. A design that accepted a nybble read, or looped once on a zero count, would make bus accesses where none are expected.

// File: rtl/wbx_pkg.sv
// Package: shared packing-mode type and the per-mode slot helper for the
// word-to-byte block transfer engine. Assumes 16-bit local words.
package wbx_pkg;

    typedef enum logic [1:0] {
        PK_FULL = 2'd0,
        PK_LOW  = 2'd1,
        PK_NYB  = 2'd2,
        PK_RSV  = 2'd3
    } pack_e;

    // Index of the last bus byte slot of one word under a given mode.
    function automatic logic [1:0] last_slot(input pack_e m);
        case (m)
            PK_FULL: last_slot = 2'd1;
            PK_NYB:  last_slot = 2'd3;
            default: last_slot = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/wbx_step_ctr.sv
// Loadable up-counter that wraps modulo 2^W. It is used for the bus byte
// address and for the local word index. Assumes load and step are never
// raised together in a way that matters (load wins).
module wbx_step_ctr #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] q
);

    // Load a start value, or advance by one with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (step) q <= q + 1'b1;
    end

endmodule

// File: rtl/wbx_lane_sel.sv
// Picks the bus byte for one slot of a 16-bit word under the packing mode.
// Full: slot 0 takes the upper half, slot 1 the lower half. Low: lower half.
// Nybble: slot n takes nybble 3-n, right-aligned, with the upper bits zero.
module wbx_lane_sel
    import wbx_pkg::*;
(
    input  logic [15:0] word,
    input  pack_e       mode,
    input  logic [1:0]  slot,
    output logic [7:0]  lane
);

    logic [3:0] nyb [4];

    // Slice the word into nybbles, most significant first.
    for (genvar g = 0; g < 4; g++) begin : g_nyb
        assign nyb[g] = word[15-4*g -: 4];
    end

    // Select the lane byte for the active mode and slot.
    always_comb begin
        case (mode)
            PK_FULL: lane = slot[0] ? word[7:0] : word[15:8];
            PK_NYB:  lane = {4'b0000, nyb[slot]};
            default: lane = word[7:0];
        endcase
    end

endmodule

// File: rtl/wbx_word_asm.sv
// Collects read bytes into a 16-bit word. Full mode: slot 0 fills the upper
// half and slot 1 the lower half. Low mode: the byte fills the lower half and
// the upper half is cleared. Assumes nybble mode never reaches this path.
module wbx_word_asm
    import wbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  pack_e       mode,
    input  logic        slot0,
    input  logic [7:0]  byte_in,
    output logic [15:0] word
);

    // Place each acknowledged byte into its half of the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (load) begin
            if (mode == PK_FULL) begin
                if (slot0) word[7:0]  <= byte_in;
                else       word[15:8] <= byte_in;
            end else begin
                word <= {8'h00, byte_in};
            end
        end
    end

endmodule

// File: rtl/wbx_block_mover.sv
// Word-to-byte block transfer engine. Takes a start pulse while idle and
// walks a run of words between the local store (one-cycle read latency) and
// the byte bus (request held until acknowledge). Rejects nybble reads and the
// reserved mode with a one-cycle err pulse. Synchronous active-low reset.
module wbx_block_mover
    import wbx_pkg::*;
#(
    parameter int BUS_AW = 20,
    parameter int LOC_AW = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BUS_AW-1:0] start_bus_addr,
    input  logic [LOC_AW-1:0] start_word_idx,
    input  logic [CNT_W-1:0]  start_words,
    input  logic              start_to_bus,
    input  logic [1:0]        start_pack,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [LOC_AW-1:0] loc_addr,
    output logic              loc_re,
    input  logic [15:0]       loc_rdata,
    output logic              loc_we,
    output logic [15:0]       loc_wdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ack
);

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CAPT, S_BUS, S_NEXT
    } state_e;

    localparam logic [CNT_W-1:0] ONE_WORD = CNT_W'(1);

    state_e           state;
    pack_e            mode_q;
    logic             wr_q;
    logic [CNT_W-1:0] left_q;
    logic [1:0]       slot_q;
    logic [15:0]      wreg;
    logic             done_q;
    logic             err_q;
    logic             bad_start;
    logic             take_start;

    assign bad_start  = (pack_e'(start_pack) == PK_RSV) ||
                        (pack_e'(start_pack) == PK_NYB && !start_to_bus);
    assign take_start = (state == S_IDLE) && start;

    // Run sequencer: fetch or wait on the bus per slot, then advance a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            mode_q <= PK_FULL;
            wr_q   <= 1'b0;
            left_q <= '0;
            slot_q <= '0;
            wreg   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        if (bad_start) begin
                            err_q <= 1'b1;
                        end else if (start_words == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            mode_q <= pack_e'(start_pack);
                            wr_q   <= start_to_bus;
                            left_q <= start_words;
                            slot_q <= '0;
                            state  <= start_to_bus ? S_FETCH : S_BUS;
                        end
                    end
                end
                S_FETCH: state <= S_CAPT;
                S_CAPT: begin
                    wreg  <= loc_rdata;
                    state <= S_BUS;
                end
                S_BUS: begin
                    if (bus_ack) begin
                        if (slot_q == last_slot(mode_q)) state <= S_NEXT;
                        else slot_q <= slot_q + 2'd1;
                    end
                end
                S_NEXT: begin
                    slot_q <= '0;
                    if (left_q == ONE_WORD) begin
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        left_q <= left_q - ONE_WORD;
                        state  <= wr_q ? S_FETCH : S_BUS;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    wbx_step_ctr #(.W(BUS_AW)) u_bus_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_start),
        .load_val (start_bus_addr),
        .step     ((state == S_BUS) && bus_ack),
        .q        (bus_addr)
    );

    wbx_step_ctr #(.W(LOC_AW)) u_loc_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_start),
        .load_val (start_word_idx),
        .step     (state == S_NEXT),
        .q        (loc_addr)
    );

    wbx_lane_sel u_lane (
        .word (wreg),
        .mode (mode_q),
        .slot (slot_q),
        .lane (bus_wdata)
    );

    wbx_word_asm u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    ((state == S_BUS) && bus_ack && !wr_q),
        .mode    (mode_q),
        .slot0   (slot_q[0]),
        .byte_in (bus_rdata),
        .word    (loc_wdata)
    );

    assign busy    = (state != S_IDLE);
    assign done    = done_q;
    assign err     = err_q;
    assign loc_re  = (state == S_FETCH);
    assign loc_we  = (state == S_NEXT) && !wr_q;
    assign bus_req = (state == S_BUS);
    assign bus_we  = wr_q;

endmodule

// File: rtl/wbx_checker.sv
// Assertion checker for wbx_block_mover. It watches the bus handshake, the
// address stepping, the lane contents and the done/err pulses. It is attached
// to every instance by the bind statement at the end of this file.
module wbx_checker
    import wbx_pkg::*;
#(
    parameter int BUS_AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              done,
    input  logic              err,
    input  logic              bus_req,
    input  logic              bus_ack,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              loc_we,
    input  logic [15:0]       loc_wdata,
    input  pack_e             mode_q
);

    logic              after_ack;
    logic [BUS_AW-1:0] prev_addr;

    // Remember the address of the last acknowledged access within a run.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            after_ack <= 1'b0;
            prev_addr <= '0;
        end else if (bus_req && bus_ack) begin
            after_ack <= 1'b1;
            prev_addr <= bus_addr;
        end else if (bus_req) begin
            after_ack <= 1'b0;
        end
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) &&
                                $stable(bus_we) && $stable(bus_wdata));

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && after_ack |-> bus_addr == BUS_AW'(prev_addr + 1'b1));

    assert_nyb_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && mode_q == PK_NYB |-> bus_wdata[7:4] == 4'h0);

    assert_low_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        loc_we && mode_q == PK_LOW |-> loc_wdata[15:8] == 8'h00);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !done);

    assert_req_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);

endmodule

bind wbx_block_mover wbx_checker #(.BUS_AW(BUS_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .loc_we    (loc_we),
    .loc_wdata (loc_wdata),
    .mode_q    (mode_q)
);

// File: tb/tb_wbx_block_mover.sv
// Sweeps mode x direction x word count x start address with varying
// acknowledge delay; expected bytes and words are computed arithmetically.
module tb_wbx_block_mover;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] start_bus_addr = '0;
    logic [15:0] start_word_idx = '0;
    logic [15:0] start_words = '0;
    logic        start_to_bus = 1'b0;
    logic [1:0]  start_pack = '0;
    logic        busy, done, err;
    logic [15:0] loc_addr;
    logic        loc_re;
    logic [15:0] loc_rdata = '0;
    logic        loc_we;
    logic [15:0] loc_wdata;
    logic        bus_req, bus_we;
    logic [19:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [15:0] lmem [256];

    // Run context seen by the bus responder.
    int          cur_mode, cur_dir, cur_widx, ack_dly;
    logic [19:0] cur_addr;
    int          acc_k;

    always #10 clk = ~clk;

    wbx_block_mover dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_bus_addr(start_bus_addr), .start_word_idx(start_word_idx),
        .start_words(start_words), .start_to_bus(start_to_bus),
        .start_pack(start_pack), .busy(busy), .done(done), .err(err),
        .loc_addr(loc_addr), .loc_re(loc_re), .loc_rdata(loc_rdata),
        .loc_we(loc_we), .loc_wdata(loc_wdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up;
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    function automatic int spw(input int m);
        return (m == 0) ? 2 : (m == 1) ? 1 : 4;
    endfunction

    function automatic logic [7:0] far_byte(input logic [19:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    // Local store: one-cycle read latency, write on strobe.
    always @(posedge clk) begin
        if (loc_re) loc_rdata <= lmem[loc_addr[7:0]];
        if (loc_we) lmem[loc_addr[7:0]] <= loc_wdata;
    end

    // Bus responder: holds off ack_dly cycles, checks each access.
    bit          seen = 0;
    int          wc = 0;
    logic [19:0] s_addr;
    logic [7:0]  s_data;
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (!seen) begin
                seen = 1; wc = 0; s_addr = bus_addr; s_data = bus_wdata;
            end
            if (wc >= ack_dly) begin
                logic [19:0] ea;
                ea = cur_addr + 20'(acc_k);
                check(bus_addr == s_addr && bus_wdata == s_data, "R9 hold", int'(bus_addr), int'(s_addr));
                check(bus_addr == ea, "R7 addr", int'(bus_addr), int'(ea));
                check(bus_we == cur_dir[0], "R9 we", int'(bus_we), cur_dir);
                if (cur_dir == 1) begin
                    logic [15:0] w;
                    logic [7:0]  eb;
                    int s;
                    w = lmem[8'(cur_widx + acc_k / spw(cur_mode))];
                    s = acc_k % spw(cur_mode);
                    if (cur_mode == 0)      eb = (s == 0) ? w[15:8] : w[7:0];
                    else if (cur_mode == 1) eb = w[7:0];
                    else                    eb = 8'((w >> (12 - 4 * s)) & 16'hF);
                    if (cur_mode == 0)      check(bus_wdata == eb, "R1 byte", bus_wdata, eb);
                    else if (cur_mode == 1) check(bus_wdata == eb, "R2 byte", bus_wdata, eb);
                    else                    check(bus_wdata == eb, "R4 nybble", bus_wdata, eb);
                end
                bus_rdata = far_byte(bus_addr);
                bus_ack = 1'b1;
                acc_k++;
                seen = 0;
            end else begin
                wc++;
            end
        end
    end

    task automatic run_one(input int m, input int d, input int n,
                           input logic [19:0] a, input int widx, input int dly);
        bit got_done = 0, got_err = 0;
        int cyc = 0;
        bit illegal;
        illegal = (m == 3) || (m == 2 && d == 0);
        for (int j = 0; j < 256; j++) lmem[j] = 16'(j * 16'h1357 + 16'hC3A9 + widx);
        cur_mode = m; cur_dir = d; cur_widx = widx; cur_addr = a;
        ack_dly = dly; acc_k = 0;
        @(negedge clk);
        start = 1; start_pack = 2'(m); start_to_bus = d[0];
        start_words = 16'(n); start_bus_addr = a; start_word_idx = 16'(widx);
        @(negedge clk);
        start = 0;
        while (!done && !err && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        got_done = done; got_err = err;
        @(negedge clk);
        if (illegal) begin
            check(got_err && !got_done, "R6 err", int'(got_err), 1);
            check(acc_k == 0, "R6 no access", acc_k, 0);
            check(cyc == 0, "R6 timing", cyc, 0);
        end else begin
            check(got_done && !got_err, "R10 done", int'(got_done), 1);
            check(acc_k == n * spw(m), "R10 count", acc_k, n * spw(m));
            check(!done, "R10 pulse", int'(done), 0);
            if (n == 0) check(cyc == 0, "R8 zero count", cyc, 0);
            if (d == 0) begin
                for (int i = 0; i < n; i++) begin
                    logic [15:0] ew;
                    logic [19:0] b;
                    if (m == 0) begin
                        b = a + 20'(2 * i);
                        ew = {far_byte(b), far_byte(b + 20'd1)};
                        check(lmem[8'(widx + i)] == ew, "R5 word", lmem[8'(widx + i)], ew);
                    end else begin
                        b = a + 20'(i);
                        ew = {8'h00, far_byte(b)};
                        check(lmem[8'(widx + i)] == ew, "R3 word", lmem[8'(widx + i)], ew);
                    end
                end
                begin
                    logic [15:0] sv;
                    sv = 16'((widx + n) * 16'h1357 + 16'hC3A9 + widx);
                    check(lmem[8'(widx + n)] == sv, "R11 beyond run", lmem[8'(widx + n)], sv);
                end
            end
        end
    endtask

    initial begin
        logic [19:0] addrs [3];
        int run = 0;
        addrs[0] = 20'h00000; addrs[1] = 20'h12345; addrs[2] = 20'hFFFFE;
        ack_dly = 0; cur_mode = 0; cur_dir = 0; cur_widx = 0; cur_addr = '0; acc_k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !done && !err && !bus_req && !loc_we && !loc_re, "reset state", int'(busy), 0);
        for (int m = 0; m < 4; m++)
            for (int d = 0; d < 2; d++)
                for (int n = 0; n < 4; n++)
                    for (int ai = 0; ai < 3; ai++) begin
                        run_one(m, d, n, addrs[ai], (run * 7) % 200, run % 3);
                        run++;
                    end
        finish_up();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_up();
    end

endmodule